// File: doc/BRIEF.md
# Direct-Mapped Cache with Miss Replay

This block is a direct-mapped, one-word-per-line cache that sits between the pipelined load/store stage of a small soft processor and a shared external memory port. Line data, tags and valid bits are read synchronously. The lookup address is therefore captured on a clock edge, and the hit or miss verdict is known only in the following cycle. By then the processor has already placed its next address on the bus.

When a lookup misses, the block raises its stall output, which freezes the processor pipeline. It then re-points the RAM read address at the request that missed and fetches that one word through a request/acknowledge memory port, which may take several cycles to answer. It writes the word into the line and reads the line again. The replayed read then hits, and only then does the pipeline move on. Writes go through to memory. A write that hits also updates the line. Addresses with the top bit set form an uncached device region, which always goes to the memory port and never fills a line.

Top module: `cache_replay_top`

## Requirements
- R1: After reset, every line is invalid, `cpu_stall`, `cpu_rvalid` and `mem_req` are low, and the first read of any cacheable address goes to memory.
- R2: A read whose line is valid with a matching tag is answered in the cycle right after it is accepted. That cycle has `cpu_rvalid` high, the stored word on `cpu_rdata`, `cpu_stall` low and no memory request.
- R3: A cacheable read miss holds `cpu_stall` high and issues exactly one single-word memory read at the missed address. After the acknowledge it writes that word into the line once, replays the lookup and returns the memory word with `cpu_rvalid`.
- R4: A request is accepted only on a clock edge where `cpu_req` is high and `cpu_stall` is low. A request that is presented during a stall waits and is served later, in program order, with correct data.
- R5: Every write, whether cacheable or not, produces one memory write of its address and data. `cpu_stall` stays high until that write is acknowledged.
- R6: A write to a cached address updates the line. A later read of that address returns the new word without any memory read.
- R7: A write to an address that is not cached does not allocate a line. The next read of that address misses and reads memory.
- R8: Word addresses with the most significant bit at 1 are uncached. Every read of them goes to memory, and the word from memory is steered to `cpu_rdata`. No line is ever filled for such an address.
- R9: Two cacheable addresses with equal index bits (the low `IDX_W` address bits) and different tags evict each other.
- R10: While `mem_req` is high and not yet acknowledged, `mem_addr`, `mem_we` and `mem_wdata` stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | ADDR_W | Word address; MSB set selects the uncached region |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data (cache line or memory word) |
| cpu_rvalid | output | 1 | Read result valid this cycle |
| cpu_stall | output | 1 | Pipeline must hold its current request |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Memory transaction is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | One-cycle completion strobe from memory |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |

## Verification
The bench first goes after the replay path. It keeps a different request on the bus during every miss. A design that fails to steer the RAM address back would compare against the wrong line and return the neighbour's word, or loop on the miss forever. Memory latency is random, with a minimum of two cycles. This catches a fill strobe that fires before the acknowledge, and a memory address that drifts while the request is still open. Directed sequences count memory reads around writes that hit, writes that miss, index conflicts and device-region reads. These expose a write that allocates, a hit that still goes to memory, and a device read that gets served stale from the cache after the bench changes the device word underneath it.

// File: rtl/cache_pkg.sv
// Shared types for the replaying cache.
// Assumes nothing beyond IEEE 1800-2017 enums.
package cache_pkg;

    // Controller phases of one CPU request.
    typedef enum logic [2:0] {
        ST_LOOKUP,  // RAM output belongs to the stage-2 request
        ST_FETCH,   // memory transaction outstanding
        ST_FILL,    // registered write strobe updates the line
        ST_REPLAY,  // RAM re-reads the stage-2 index
        ST_DONE     // write or uncached read retires
    } cache_state_t;

endpackage

// File: rtl/cache_store.sv
// Line storage: data, tag and valid arrays with a registered read port.
// Assumes read-first behaviour: a read and a write to the same index in one
// cycle return the old contents. Valid bits are flops so reset clears them.
module cache_store #(
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0]  valid_bits;
    logic [TAG_W-1:0]  tag_ram  [LINES];
    logic [DATA_W-1:0] data_ram [LINES];

    // Valid bits: cleared by reset, set by each fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_bits <= '0;
            rd_valid   <= 1'b0;
        end else begin
            if (wr_en) valid_bits[wr_idx] <= 1'b1;
            rd_valid <= valid_bits[rd_idx];
        end
    end

    // Tag and data arrays: synchronous write, registered read-first output.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_ram[wr_idx]  <= wr_tag;
            data_ram[wr_idx] <= wr_data;
        end
        rd_tag  <= tag_ram[rd_idx];
        rd_data <= data_ram[rd_idx];
    end

endmodule

// File: rtl/cache_ctrl.sv
// Stage-2 request register, hit compare, miss state machine and the replay
// multiplexer on the RAM read address. Assumes the store returns data for
// the index presented one edge earlier, and that mem_ack is a one-cycle
// strobe carrying mem_rdata. Address MSB selects the uncached region.
module cache_ctrl
    import cache_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rvalid,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [IDX_W-1:0]  ram_idx,
    input  logic              rd_valid,
    input  logic [ADDR_W-IDX_W-1:0] rd_tag,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [ADDR_W-IDX_W-1:0] wr_tag,
    output logic [DATA_W-1:0] wr_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    cache_state_t      state;
    logic              s2_valid, s2_we, s2_whit, wr_en_q;
    logic [ADDR_W-1:0] s2_addr;
    logic [DATA_W-1:0] s2_wdata, fill_data;
    logic              s2_uncached, tag_match, read_hit, done, accept;
    logic [TAG_W-1:0]  s2_tag;
    logic [IDX_W-1:0]  s2_idx;

    // Field split of the stage-2 address.
    assign s2_uncached = s2_addr[ADDR_W-1];
    assign s2_tag      = s2_addr[ADDR_W-1:IDX_W];
    assign s2_idx      = s2_addr[IDX_W-1:0];

    // Hit compare on the registered RAM output.
    assign tag_match = rd_valid && (rd_tag == s2_tag);
    assign read_hit  = (state == ST_LOOKUP) && !s2_we && !s2_uncached && tag_match;

    // Retirement, stall and acceptance of the next request.
    assign done       = s2_valid && (read_hit || state == ST_DONE);
    assign cpu_stall  = s2_valid && !done;
    assign cpu_rvalid = done && !s2_we;
    assign accept     = cpu_req && !cpu_stall;

    // Read data mux: cache line, or the word fetched from the uncached region.
    assign cpu_rdata = (state == ST_DONE) ? fill_data : rd_data;

    // Replay mux: during a stall the RAM re-reads the stalled request's line.
    assign ram_idx = cpu_stall ? s2_idx : cpu_addr[IDX_W-1:0];

    // Memory port driven straight from the held stage-2 request.
    assign mem_req   = (state == ST_FETCH);
    assign mem_we    = s2_we;
    assign mem_addr  = s2_addr;
    assign mem_wdata = s2_wdata;

    // Line write port.
    assign wr_en   = wr_en_q;
    assign wr_idx  = s2_idx;
    assign wr_tag  = s2_tag;
    assign wr_data = fill_data;

    // Stage-2 request register: loads on acceptance, empties on retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_we    <= 1'b0;
            s2_addr  <= '0;
            s2_wdata <= '0;
        end else if (accept) begin
            s2_valid <= 1'b1;
            s2_we    <= cpu_we;
            s2_addr  <= cpu_addr;
            s2_wdata <= cpu_wdata;
        end else if (done) begin
            s2_valid <= 1'b0;
        end
    end

    // Miss sequencing with a registered line write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_LOOKUP;
            s2_whit   <= 1'b0;
            wr_en_q   <= 1'b0;
            fill_data <= '0;
        end else begin
            unique case (state)
                ST_LOOKUP: if (s2_valid && !done) begin
                    s2_whit <= tag_match && !s2_uncached;
                    state   <= ST_FETCH;
                end
                ST_FETCH: if (mem_ack) begin
                    fill_data <= s2_we ? s2_wdata : mem_rdata;
                    if (s2_we ? s2_whit : !s2_uncached) begin
                        wr_en_q <= 1'b1;
                        state   <= ST_FILL;
                    end else begin
                        state <= ST_DONE;
                    end
                end
                ST_FILL: begin
                    wr_en_q <= 1'b0;
                    state   <= s2_we ? ST_DONE : ST_REPLAY;
                end
                ST_REPLAY: state <= ST_LOOKUP;
                ST_DONE:   state <= ST_LOOKUP;
                default:   state <= ST_LOOKUP;
            endcase
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10
    AST_FILL_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(mem_ack)); // R3
    AST_SINGLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R3
    AST_STALL_DURING_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> cpu_stall); // R5
    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |=> $stable(s2_addr)); // R4
    AST_UNCACHED_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !s2_addr[ADDR_W-1]); // R8

endmodule

// File: rtl/cache_replay_top.sv
// Top of the replaying direct-mapped cache: wires the controller to the
// line store. Assumes word addressing and a single-word memory port.
module cache_replay_top #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rvalid,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  ram_idx, wr_idx;
    logic              rd_valid, wr_en;
    logic [TAG_W-1:0]  rd_tag, wr_tag;
    logic [DATA_W-1:0] rd_data, wr_data;

    cache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
        .clk, .rst_n,
        .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata,
        .cpu_rdata, .cpu_rvalid, .cpu_stall,
        .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata,
        .ram_idx, .rd_valid, .rd_tag, .rd_data,
        .wr_en, .wr_idx, .wr_tag, .wr_data
    );

    cache_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk, .rst_n,
        .rd_idx(ram_idx), .wr_en, .wr_idx, .wr_tag, .wr_data,
        .rd_valid, .rd_tag, .rd_data
    );

endmodule

// File: tb/tb_cache_replay_top.sv
// Scoreboard bench: the driver queues the expected read words, a monitor
// pops and compares them on cpu_rvalid, and a memory model answers with
// random latency while counting reads and writes.
module tb_cache_replay_top;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic [DATA_W-1:0] cpu_rdata;
    logic              cpu_rvalid, cpu_stall;
    logic              mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_ack = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;

    cache_replay_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) dut (.*);

    always #4 clk = ~clk;

    logic [DATA_W-1:0] ext_mem [1<<ADDR_W];
    logic [DATA_W-1:0] ref_mem [1<<ADDR_W];
    logic [DATA_W-1:0] exp_q[$];
    int checks = 0, errors = 0, rd_cnt = 0, wr_cnt = 0, cyc = 0;
    bit done_flag = 0;

    task automatic chk(input bit ok, input string req, input logic [DATA_W-1:0] got,
                       input logic [DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Memory model: random latency of at least two cycles, one-cycle ack.
    bit busy = 0;
    int lat = 0;
    logic [ADDR_W-1:0] held_addr;
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 0; busy = 0;
        end else if (mem_ack) begin
            mem_ack = 0; busy = 0;
        end else if (mem_req) begin
            if (!busy) begin
                busy = 1; lat = $urandom_range(2, 5); held_addr = mem_addr;
            end else begin
                chk(mem_addr === held_addr, "R10 addr held", {20'd0, mem_addr}, {20'd0, held_addr});
            end
            lat--;
            if (lat == 0) begin
                mem_ack = 1;
                if (mem_we) begin
                    ext_mem[mem_addr] = mem_wdata; wr_cnt++;
                end else begin
                    mem_rdata = ext_mem[mem_addr]; rd_cnt++;
                end
            end
        end
    end

    // Monitor: every read result is compared with the queued expectation.
    always @(negedge clk) begin
        if (rst_n && cpu_rvalid) begin
            if (exp_q.size() == 0) chk(0, "R4 unexpected rvalid", cpu_rdata, '0);
            else begin
                logic [DATA_W-1:0] e;
                e = exp_q.pop_front();
                chk(cpu_rdata === e, "R3 read data", cpu_rdata, e);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: got %0d expected 0", cyc);
            finish_run();
        end
    end

    // Driver: present a request, hold it until accepted (R4).
    task automatic issue(input bit we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        if (we) ref_mem[a] = d;
        else exp_q.push_back(ref_mem[a]);
        while (cpu_stall) @(negedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        cpu_req = 0; cpu_we = 0;
        while (exp_q.size() != 0 || cpu_stall) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    localparam logic [ADDR_W-1:0] A = 12'h010, B = 12'h023, C = 12'h050, U = 12'h810;

    initial begin
        int r0, w0;
        for (int i = 0; i < (1<<ADDR_W); i++) begin
            ext_mem[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
            ref_mem[i] = ext_mem[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(!cpu_stall, "R1 stall low", {31'd0, cpu_stall}, 0);
        chk(!mem_req, "R1 mem_req low", {31'd0, mem_req}, 0);
        chk(!cpu_rvalid, "R1 rvalid low", {31'd0, cpu_rvalid}, 0);

        // R1/R3: first read misses and goes to memory
        r0 = rd_cnt;
        issue(0, A, 0); idle();
        chk(rd_cnt - r0 == 1, "R1 R3 first read misses", rd_cnt - r0, 1);

        // R2: hit answered the next cycle without memory
        r0 = rd_cnt;
        issue(0, A, 0);
        @(negedge clk);
        chk(cpu_rvalid && !cpu_stall, "R2 hit next cycle", {31'd0, cpu_rvalid}, 1);
        cpu_req = 0;
        idle();
        chk(rd_cnt == r0, "R2 no memory read on hit", rd_cnt - r0, 0);

        // R4: back-to-back stream, misses mixed with hits
        for (int i = 0; i < 8; i++) issue(0, 12'h100 + i, 0);
        issue(0, A, 0);
        for (int i = 0; i < 8; i++) issue(0, 12'h100 + i, 0);
        idle();
        r0 = rd_cnt;
        for (int i = 0; i < 8; i++) issue(0, 12'h100 + i, 0);
        idle();
        chk(rd_cnt == r0, "R4 warmed lines all hit", rd_cnt - r0, 0);

        // R5/R6: write hit updates line and memory
        r0 = rd_cnt; w0 = wr_cnt;
        issue(1, A, 32'hCAFE0001); idle();
        chk(wr_cnt - w0 == 1, "R5 one memory write", wr_cnt - w0, 1);
        chk(ext_mem[A] === 32'hCAFE0001, "R5 memory updated", ext_mem[A], 32'hCAFE0001);
        issue(0, A, 0); idle();
        chk(rd_cnt == r0, "R6 write hit read hits", rd_cnt - r0, 0);

        // R7: write miss does not allocate
        issue(1, B, 32'h0BAD0002); idle();
        r0 = rd_cnt;
        issue(0, B, 0); idle();
        chk(rd_cnt - r0 == 1, "R7 no allocate on write miss", rd_cnt - r0, 1);

        // R9: same index, different tag evicts
        r0 = rd_cnt;
        issue(0, C, 0); issue(0, A, 0); idle();
        chk(rd_cnt - r0 == 2, "R9 conflict evicts", rd_cnt - r0, 2);

        // R8: uncached reads always go to memory
        r0 = rd_cnt;
        issue(0, U, 0); idle();
        ext_mem[U] = 32'h1234ABCD; ref_mem[U] = 32'h1234ABCD;
        issue(0, U, 0); idle();
        chk(rd_cnt - r0 == 2, "R8 uncached never cached", rd_cnt - r0, 2);

        // R3/R4/R5: random pipelined mix
        for (int n = 0; n < 300; n++) begin
            logic [ADDR_W-1:0] a;
            a = {($urandom_range(0, 9) == 0) ? 1'b1 : 1'b0, 3'd0,
                 2'($urandom_range(0, 3)), 3'd0, 3'($urandom_range(0, 7))};
            issue($urandom_range(0, 9) < 3, a, $urandom);
        end
        idle();
        chk(exp_q.size() == 0, "R4 all reads answered", exp_q.size(), 0);

        finish_run();
    end
endmodule